// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block is the tag and state store of a four-way set-associative cache. For every way of every set it keeps a line tag, a two-bit access permission and a lock owner. A requester presents one line-aligned address per cycle together with an operation code. The block answers in the same cycle through combinational outputs. Any state change the operation causes takes effect at the next rising clock edge.

The operations fall into five groups:
- Access checks, which grant or deny a request by the line's permission and the request kind.
- Presence and availability queries.
- Allocation, deallocation and permission update.
- Lock set, lock clear and lock test.
- A victim probe, which names the line that a tree pseudo-LRU per set would evict.

Misuse raises an error flag for that cycle and changes no state. Misuse here means allocating a line that is already present, allocating into a full set, or a lock operation on an absent line.

Top module: `cache_tag_dir`

## Requirements
- R1: The number of sets is CACHE_BYTES / 4 / LINE_BYTES and must be greater than one. The set is taken from address bits [IDX_LSB +: log2(sets)]. Lines in different sets never hit each other.
- R2: The presence query (op 2) reports hit_o=1 only when a way of the set holds the same line address and its permission is not NotPresent. The permission codes are 0 NotPresent, 1 Invalid, 2 ReadOnly and 3 ReadWrite. way_o gives the hitting way.
- R3: The access check (op 1) uses the request kinds 0 load, 1 fetch, 2 store and 3 atomic. It grants any kind on a ReadWrite line, and only loads and fetches on a ReadOnly line. It denies everything else, including a hit on an Invalid line.
- R4: An access check that hits updates the set's replacement state even when it is denied. The presence query leaves that state unchanged.
- R5: The availability query (op 3) sets avail_o when the line is present in its set or when some way of the set is NotPresent.
- R6: Allocation (op 4) takes the lowest-numbered NotPresent way and reports it on way_o. It writes the tag, sets the permission to Invalid, clears the lock and marks the way most recently used.
- R7: Allocation of a present line, or into a set with no NotPresent way, raises err_o and changes nothing.
- R8: Deallocation (op 5) of a present line sets its way to NotPresent. Deallocation of an absent line has no effect.
- R9: Lock set (op 7) stores req_ctx_i as the owner, and lock clear (op 8) unlocks the line. Lock test (op 9) sets lock_match_o only when the line is locked by exactly req_ctx_i.
- R10: A lock set, clear or test on an absent line raises err_o and changes nothing.
- R11: Each set keeps three tree bits, all zero after reset. The root bit selects the pair of ways (0: ways 0-1, 1: ways 2-3). The second bit selects within ways 0-1 and the third within ways 2-3. A touch points the bits on the path away from the touched way. The probe (op 6) reports the way those bits select on victim_way_o, and that way's line address on victim_addr_o.
- R12: Permission update (op 10) writes req_perm_i into a present line. On an absent line it does nothing.
- R13: err_o is raised only by allocation and lock operations. An access, presence query, deallocation or probe never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 4 | Operation code |
| req_addr_i | input | ADDR_W | Line-aligned address |
| req_kind_i | input | 2 | Request kind for access checks |
| req_ctx_i | input | CTX_W | Context id for lock operations |
| req_perm_i | input | 2 | Permission for the update operation |
| hit_o | output | 1 | Line present in its set |
| way_o | output | 2 | Hitting way, or the chosen way on allocation |
| grant_o | output | 1 | Access check granted |
| avail_o | output | 1 | Availability query result |
| lock_match_o | output | 1 | Lock test result |
| victim_addr_o | output | ADDR_W | Line address of the victim on a probe |
| victim_way_o | output | 2 | Victim way on a probe |
| err_o | output | 1 | Misuse of allocation or lock operations |

## Verification
A wrong tag, permission or lock bit shows up at the next operation on that line, one cycle after the write that should have set it. It appears as a stale hit, a wrong grant or a wrong lock answer. A corrupted tree bit stays hidden until a probe of that set; the tests therefore probe after each touch pattern, so a wrong victim appears within one cycle of the touch that caused it. Misrouted allocation shows up at once on way_o and err_o, and again on a later presence query of the same line.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_ACCESS    = 4'd1,
    OP_PRESENT   = 4'd2,
    OP_AVAIL     = 4'd3,
    OP_ALLOC     = 4'd4,
    OP_DEALLOC   = 4'd5,
    OP_PROBE     = 4'd6,
    OP_LOCK_SET  = 4'd7,
    OP_LOCK_CLR  = 4'd8,
    OP_LOCK_TEST = 4'd9,
    OP_SET_PERM  = 4'd10
  } op_e;

  // tree bits: [0] root (1 = victim in ways 2-3), [1] ways 0-1, [2] ways 2-3
  function automatic logic [2:0] plru_touch(logic [2:0] t, logic [1:0] way);
    logic [2:0] n;
    n    = t;
    n[0] = ~way[1];
    if (way[1]) n[2] = ~way[0];
    else        n[1] = ~way[0];
    return n;
  endfunction

  function automatic logic [1:0] plru_victim(logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction
endpackage

// File: rtl/tdir_plru.sv
module tdir_plru #(
  parameter int SETS  = 16,
  parameter int SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [1:0]       touch_way_i,
  output logic [1:0]       victim_way_o
);
  import tdir_pkg::*;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_i) begin
      tree_q[set_i] <= plru_touch(tree_q[set_i], touch_way_i);
    end
  end

  assign victim_way_o = plru_victim(tree_q[set_i]);
endmodule

// File: rtl/tdir_lookup.sv
module tdir_lookup #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag_i,
  input  logic [WAYS-1:0][1:0]       row_perm_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  import tdir_pkg::*;

  logic [WAYS-1:0] match;
  logic [WAYS-1:0] empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign empty[w] = (row_perm_i[w] == PERM_NONE);
    assign match[w] = !empty[w] && (row_tag_i[w] == tag_i);
  end

  // lowest index wins for both encoders
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way_o  = WAY_W'(w);
      if (empty[w]) free_way_o = WAY_W'(w);
    end
  end

  assign hit_o  = |match;
  assign free_o = |empty;
endmodule

// File: rtl/tdir_grant.sv
module tdir_grant (
  input  logic [1:0] perm_i,
  input  logic [1:0] kind_i,
  output logic       ok_o
);
  import tdir_pkg::*;

  always_comb begin
    unique case (perm_i)
      PERM_RW: ok_o = 1'b1;
      PERM_RO: ok_o = (kind_i == KIND_LOAD) || (kind_i == KIND_FETCH);
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 64,
  parameter int IDX_LSB     = 6,
  parameter int CTX_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [3:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic [1:0]        req_perm_i,
  output logic              hit_o,
  output logic [1:0]        way_o,
  output logic              grant_o,
  output logic              avail_o,
  output logic              lock_match_o,
  output logic [ADDR_W-1:0] victim_addr_o,
  output logic [1:0]        victim_way_o,
  output logic              err_o
);
  import tdir_pkg::*;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
  localparam int SET_W = $clog2(SETS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q      [SETS];
  logic [WAYS-1:0][1:0]       perm_q     [SETS];
  logic [WAYS-1:0]            lock_vld_q [SETS];
  logic [WAYS-1:0][CTX_W-1:0] lock_ctx_q [SETS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             unused_lo;
  op_e              op;

  assign set_idx   = req_addr_i[IDX_LSB +: SET_W];
  assign tag       = req_addr_i[ADDR_W-1:OFF_W];
  assign unused_lo = ^req_addr_i[OFF_W-1:0];
  assign op        = op_e'(req_op_i);

  logic             hit, free;
  logic [WAY_W-1:0] hit_way, free_way, vic_way;
  logic             perm_ok;

  tdir_lookup #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_lookup (
    .row_tag_i  (tag_q[set_idx]),
    .row_perm_i (perm_q[set_idx]),
    .tag_i      (tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .free_o     (free),
    .free_way_o (free_way)
  );

  tdir_grant u_grant (
    .perm_i (perm_q[set_idx][hit_way]),
    .kind_i (req_kind_i),
    .ok_o   (perm_ok)
  );

  logic is_acc, is_alloc, is_dealloc, is_probe, is_lset, is_lclr, is_ltest, is_perm, is_lock;
  assign is_acc     = req_valid_i && (op == OP_ACCESS);
  assign is_alloc   = req_valid_i && (op == OP_ALLOC);
  assign is_dealloc = req_valid_i && (op == OP_DEALLOC);
  assign is_probe   = req_valid_i && (op == OP_PROBE);
  assign is_lset    = req_valid_i && (op == OP_LOCK_SET);
  assign is_lclr    = req_valid_i && (op == OP_LOCK_CLR);
  assign is_ltest   = req_valid_i && (op == OP_LOCK_TEST);
  assign is_perm    = req_valid_i && (op == OP_SET_PERM);
  assign is_lock    = is_lset || is_lclr || is_ltest;

  logic alloc_ok, touch;
  logic [WAY_W-1:0] touch_way;
  assign alloc_ok  = is_alloc && !hit && free;
  assign touch     = (is_acc && hit) || alloc_ok;
  assign touch_way = alloc_ok ? free_way : hit_way;

  tdir_plru #(.SETS(SETS), .SET_W(SET_W)) u_plru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_idx),
    .touch_i      (touch),
    .touch_way_i  (touch_way),
    .victim_way_o (vic_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]      <= '0;
        perm_q[s]     <= '0;
        lock_vld_q[s] <= '0;
        lock_ctx_q[s] <= '0;
      end
    end else if (alloc_ok) begin
      tag_q[set_idx][free_way]      <= tag;
      perm_q[set_idx][free_way]     <= PERM_INV;
      lock_vld_q[set_idx][free_way] <= 1'b0;
    end else if (hit) begin
      if (is_dealloc) begin
        perm_q[set_idx][hit_way]     <= PERM_NONE;
        lock_vld_q[set_idx][hit_way] <= 1'b0;
      end
      if (is_perm) perm_q[set_idx][hit_way] <= req_perm_i;
      if (is_lset) begin
        lock_vld_q[set_idx][hit_way] <= 1'b1;
        lock_ctx_q[set_idx][hit_way] <= req_ctx_i;
      end
      if (is_lclr) lock_vld_q[set_idx][hit_way] <= 1'b0;
    end
  end

  assign hit_o        = req_valid_i && hit;
  assign way_o        = is_alloc ? free_way : hit_way;
  assign grant_o      = is_acc && hit && perm_ok;
  assign avail_o      = req_valid_i && (op == OP_AVAIL) && (hit || free);
  assign lock_match_o = is_ltest && hit && lock_vld_q[set_idx][hit_way]
                        && (lock_ctx_q[set_idx][hit_way] == req_ctx_i);
  assign victim_way_o  = is_probe ? vic_way : '0;
  assign victim_addr_o = is_probe ? {tag_q[set_idx][vic_way], {OFF_W{1'b0}}} : '0;
  assign err_o        = (is_alloc && (hit || !free)) || (is_lock && !hit);
endmodule

// File: rtl/tdir_checker.sv
module tdir_checker #(
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [3:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [CTX_W-1:0]  req_ctx_i,
  input logic              hit_o,
  input logic              grant_o,
  input logic              lock_match_o,
  input logic              err_o
);
  import tdir_pkg::*;

  logic same_line;
  assign same_line = 1'b0;

  // R6: a successful allocation is visible on the next cycle
  p_alloc_visible_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_ALLOC && !err_o)
      |=> (!(req_valid_i && req_addr_i == $past(req_addr_i)) || hit_o));

  // R7: rejected allocation of a present line keeps it present
  p_alloc_err_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_ALLOC && err_o && hit_o)
      |=> (!(req_valid_i && req_addr_i == $past(req_addr_i)) || hit_o));

  // R8: a deallocated line is absent on the next cycle
  p_dealloc_gone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_DEALLOC)
      |=> (!(req_valid_i && req_addr_i == $past(req_addr_i)) || !hit_o));

  // R9: lock set then test by the same owner matches
  p_lock_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_LOCK_SET && !err_o)
      |=> (!(req_valid_i && req_op_i == OP_LOCK_TEST && req_addr_i == $past(req_addr_i)
             && req_ctx_i == $past(req_ctx_i)) || lock_match_o));

  // R9: lock clear then test never matches
  p_lock_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_LOCK_CLR && !err_o)
      |=> (!(req_valid_i && req_op_i == OP_LOCK_TEST && req_addr_i == $past(req_addr_i))
           || !lock_match_o));

  // R13: only allocation and lock operations raise the error flag
  p_err_ops_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (req_valid_i && (req_op_i == OP_ALLOC || req_op_i == OP_LOCK_SET
               || req_op_i == OP_LOCK_CLR || req_op_i == OP_LOCK_TEST)));

  // R3: a grant needs an access check that hits
  p_grant_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (hit_o && req_op_i == OP_ACCESS));
endmodule

bind cache_tag_dir tdir_checker #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_addr_i   (req_addr_i),
  .req_ctx_i    (req_ctx_i),
  .hit_o        (hit_o),
  .grant_o      (grant_o),
  .lock_match_o (lock_match_o),
  .err_o        (err_o)
);

// File: tb/cache_tag_dir_tb_top.sv
module cache_tag_dir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CTX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [3:0]        req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_kind_i = '0;
  logic [CTX_W-1:0]  req_ctx_i = '0;
  logic [1:0]        req_perm_i = '0;
  logic              hit_o, grant_o, avail_o, lock_match_o, err_o;
  logic [1:0]        way_o, victim_way_o;
  logic [ADDR_W-1:0] victim_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_dir dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_kind_i(req_kind_i), .req_ctx_i(req_ctx_i),
    .req_perm_i(req_perm_i), .hit_o(hit_o), .way_o(way_o), .grant_o(grant_o),
    .avail_o(avail_o), .lock_match_o(lock_match_o), .victim_addr_o(victim_addr_o),
    .victim_way_o(victim_way_o), .err_o(err_o)
  );

  localparam logic [3:0] ACC = 1, PRES = 2, AVL = 3, ALC = 4, DAL = 5, PRB = 6,
                         LSET = 7, LCLR = 8, LTST = 9, SPERM = 10;

  function automatic logic [31:0] mk(int t, int s);
    return (32'(t) << 10) | (32'(s) << 6);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, outputs settle before the next rising edge
  task automatic op(logic [3:0] o, logic [31:0] a, logic [1:0] k = 0,
                    logic [CTX_W-1:0] c = 0, logic [1:0] p = 0);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = o; req_addr_i = a;
    req_kind_i = k; req_ctx_i = c; req_perm_i = p;
    #1;
  endtask

  task automatic t_reset;
    op(PRES, mk(1, 0));
    chk("R2", "hit after reset", hit_o, 0);
    chk("R13", "err presence", err_o, 0);
    op(AVL, mk(1, 0));
    chk("R5", "avail empty set", avail_o, 1);
    op(PRB, mk(1, 0));
    chk("R11", "victim way reset", victim_way_o, 0);
    chk("R11", "victim addr reset", victim_addr_o, 0);
  endtask

  task automatic t_alloc;
    logic [31:0] a = mk(1, 0);
    op(ALC, a);
    chk("R6", "alloc err", err_o, 0);
    chk("R6", "alloc way", way_o, 0);
    op(PRES, a);
    chk("R2", "hit", hit_o, 1);
    chk("R2", "hit way", way_o, 0);
    op(ACC, a, 0);
    chk("R3", "invalid hit", hit_o, 1);
    chk("R3", "invalid load denied", grant_o, 0);
    chk("R13", "access err", err_o, 0);
    op(LTST, a, 0, 0);
    chk("R6", "fresh line unlocked", lock_match_o, 0);
    op(ALC, a);
    chk("R7", "alloc present err", err_o, 1);
    op(PRES, a);
    chk("R7", "still present way", {31'd0, hit_o} | (32'(way_o) << 4), 1);
  endtask

  task automatic t_perm;
    logic [31:0] a = mk(1, 0);
    op(SPERM, a, 0, 0, 2);
    op(ACC, a, 0); chk("R3", "RO load", grant_o, 1);
    op(ACC, a, 1); chk("R3", "RO fetch", grant_o, 1);
    op(ACC, a, 2); chk("R3", "RO store", grant_o, 0);
    op(ACC, a, 3); chk("R3", "RO atomic", grant_o, 0);
    op(SPERM, a, 0, 0, 3);
    op(ACC, a, 2); chk("R12", "RW store", grant_o, 1);
    op(ACC, a, 3); chk("R3", "RW atomic", grant_o, 1);
    op(SPERM, mk(2, 0), 0, 0, 3);
    op(PRES, mk(2, 0)); chk("R12", "perm on absent", hit_o, 0);
  endtask

  task automatic t_fill_plru;
    for (int i = 0; i < 4; i++) begin
      op(ALC, mk(i + 1, 1));
      chk("R6", "fill way", way_o, 32'(i));
    end
    op(AVL, mk(5, 1)); chk("R5", "full set avail", avail_o, 0);
    op(AVL, mk(3, 1)); chk("R5", "present avail", avail_o, 1);
    op(ALC, mk(5, 1)); chk("R7", "alloc full err", err_o, 1);
    op(PRB, mk(5, 1));
    chk("R11", "victim after fill", victim_way_o, 0);
    chk("R11", "victim addr", victim_addr_o, mk(1, 1));
    op(PRES, mk(1, 1));
    op(PRB, mk(1, 1)); chk("R4", "presence no touch", victim_way_o, 0);
    op(ACC, mk(1, 1), 2); chk("R3", "invalid store denied", grant_o, 0);
    op(PRB, mk(1, 1));
    chk("R4", "denied access touches", victim_way_o, 2);
    chk("R11", "victim addr way2", victim_addr_o, mk(3, 1));
    op(ACC, mk(3, 1), 0);
    op(PRB, mk(3, 1));
    chk("R11", "victim way1", victim_way_o, 1);
    chk("R11", "victim addr way1", victim_addr_o, mk(2, 1));
  endtask

  task automatic t_dealloc;
    op(DAL, mk(2, 1)); chk("R13", "dealloc err", err_o, 0);
    op(PRES, mk(2, 1)); chk("R8", "gone", hit_o, 0);
    op(AVL, mk(6, 1)); chk("R5", "freed avail", avail_o, 1);
    op(ALC, mk(6, 1));
    chk("R6", "reuse lowest free", way_o, 1);
    chk("R6", "reuse err", err_o, 0);
    op(DAL, mk(9, 1));
    op(PRES, mk(1, 1));
    chk("R8", "absent dealloc harmless", hit_o, 1);
    op(AVL, mk(9, 1)); chk("R5", "full again", avail_o, 0);
  endtask

  task automatic t_lock;
    logic [31:0] a = mk(1, 2);
    op(ALC, a);
    op(LSET, a, 0, 5); chk("R9", "lock set err", err_o, 0);
    op(LTST, a, 0, 5); chk("R9", "owner match", lock_match_o, 1);
    op(LTST, a, 0, 3); chk("R9", "other ctx", lock_match_o, 0);
    op(LCLR, a);
    op(LTST, a, 0, 5); chk("R9", "after clear", lock_match_o, 0);
    op(LSET, mk(7, 2), 0, 5); chk("R10", "lock absent err", err_o, 1);
    op(LTST, mk(7, 2), 0, 5);
    chk("R10", "test absent err", err_o, 1);
    chk("R10", "test absent match", lock_match_o, 0);
    op(PRES, mk(7, 2)); chk("R10", "no alloc by lock", hit_o, 0);
    op(LSET, a, 0, 5);
    op(DAL, a);
    op(ALC, a);
    op(LTST, a, 0, 5); chk("R6", "alloc clears lock", lock_match_o, 0);
  endtask

  task automatic t_sets;
    op(ALC, mk(1, 3));
    op(PRES, mk(1, 4)); chk("R1", "neighbour set miss", hit_o, 0);
    op(PRES, mk(1, 3)); chk("R1", "own set hit", hit_o, 1);
    op(ALC, mk(1, 15)); chk("R1", "top set way", way_o, 0);
    op(PRES, mk(1, 14)); chk("R1", "set 14 miss", hit_o, 0);
    op(PRES, mk(0, 3)); chk("R1", "tag differs", hit_o, 0);
    op(ACC, mk(8, 3), 0); chk("R13", "access absent err", err_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_reset();
    t_alloc();
    t_perm();
    t_fill_plru();
    t_dealloc();
    t_lock();
    t_sets();
    @(negedge clk) req_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule